// File: doc/BRIEF.md
# I2C SCL Duty-Cycle Clock Divider

This block times the two halves of an I2C clock from a fast source clock. Software writes a 24-bit control word that holds two divider fields: one for the low half and one for the high half. Each half lasts its divider value plus a fixed three-cycle overhead. If the high field is zero, the high half reuses the low divider and the clock is symmetric, as in standard mode. A nonzero high field gives the uneven split that the faster bus rates need, roughly one third high and two thirds low. Working out the divider values is left to software. The block only applies the fields it is given.

The I2C sequencer sets `enable` and receives a one-cycle strobe at the start of each low half and at the start of each counted high half. It uses these strobes to move its data line at the right moments. The block releases SCL for the high half, but it only counts high cycles while the sensed bus level is actually high. A slave that keeps SCL low therefore stretches the clock without losing any high time. The block samples the control word once per period, at the start of each low half. A new word therefore never changes a period that is already under way.

Top module: `scl_phase_gen`

## Requirements
- R1: After reset, and whenever no period is in progress, `busy` is 0, `scl_low` is 0 (SCL released) and both strobes are 0.
- R2: Each low half lasts ctrl_word[7:0] + 3 clock cycles, with `scl_low` = 1 throughout.
- R3: When ctrl_word[23:16] is nonzero, the high half lasts ctrl_word[23:16] + 3 cycles in which `scl_sense` is 1.
- R4: When ctrl_word[23:16] is zero, the high half lasts ctrl_word[7:0] + 3 sensed-high cycles, so the clock is symmetric.
- R5: ctrl_word[15:8] has no effect on either half's length.
- R6: The control word is sampled when a low half begins, so a change written during a period takes effect from the next period.
- R7: During the high half, cycles with `scl_sense` = 0 are not counted and the period cannot end, so a slave holding SCL low lengthens the high half by exactly the hold time.
- R8: `fall_stb` is high for exactly the first cycle of each low half. `rise_stb` is high for exactly the first counted cycle of each high half.
- R9: When `enable` is 0 at the end of a high half, the block goes idle after that half completes. When it is 1, the next low half follows immediately.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run request from the sequencer |
| ctrl_word | input | 24 | Low divider [7:0], ignored [15:8], high divider [23:16] |
| scl_sense | input | 1 | Sampled SCL bus level (1 = high) |
| scl_low | output | 1 | 1 = pull SCL low, 0 = release |
| busy | output | 1 | A period is in progress |
| fall_stb | output | 1 | First cycle of a low half |
| rise_stb | output | 1 | First counted cycle of a high half |

## Verification
Symmetric words with several low dividers check the overhead and the fallback to the low divider. Asymmetric words, including a short high field paired with the largest low field, show that the two halves are timed independently. A pair of words that differ only in the middle byte shows whether that byte leaks into the timing. A word changed after the second period has started separates sampling at the period boundary from sampling partway through a period. A slave hold applied at every release separates counting sensed-high cycles from counting released cycles.

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
  parameter int DIV_W = 8,
  parameter int EXTRA = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [3*DIV_W-1:0] ctrl_word,
  input  logic               scl_sense,
  output logic               scl_low,
  output logic               busy,
  output logic               fall_stb,
  output logic               rise_stb
);
  localparam int LEN_W  = DIV_W + 2;
  localparam int HI_LSB = 2 * DIV_W;

  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH} phase_t;

  phase_t             st;
  logic [LEN_W-1:0]   cnt;
  logic [DIV_W-1:0]   lo_q, hi_q;
  logic [LEN_W-1:0]   lo_len, hi_len;
  logic               unused_mid;

  assign unused_mid = ^ctrl_word[HI_LSB-1:DIV_W];

  assign lo_len = LEN_W'(lo_q) + LEN_W'(EXTRA);
  assign hi_len = LEN_W'((hi_q == '0) ? lo_q : hi_q) + LEN_W'(EXTRA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cnt  <= '0;
      lo_q <= '0;
      hi_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (enable) begin
          st   <= S_LOW;
          cnt  <= '0;
          lo_q <= ctrl_word[DIV_W-1:0];
          hi_q <= ctrl_word[HI_LSB +: DIV_W];
        end
        S_LOW: begin
          if (cnt == lo_len - 1'b1) begin
            st  <= S_HIGH;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_HIGH: if (scl_sense) begin
          if (cnt == hi_len - 1'b1) begin
            cnt <= '0;
            if (enable) begin
              st   <= S_LOW;
              lo_q <= ctrl_word[DIV_W-1:0];
              hi_q <= ctrl_word[HI_LSB +: DIV_W];
            end else begin
              st <= S_IDLE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign scl_low  = (st == S_LOW);
  assign busy     = (st != S_IDLE);
  assign fall_stb = (st == S_LOW) && (cnt == '0);
  assign rise_stb = (st == S_HIGH) && (cnt == '0) && scl_sense;
endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_sense,
  input logic scl_low,
  input logic busy,
  input logic fall_stb,
  input logic rise_stb
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!scl_low && !fall_stb && !rise_stb)); // R1
  AST_STRB_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(fall_stb && rise_stb)); // R8
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) fall_stb |=> !fall_stb); // R8
  AST_FALL_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n) fall_stb |-> scl_low); // R8
  AST_LOW_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(scl_low) |-> fall_stb); // R8
  AST_NO_RISE_HELD: assert property (@(posedge clk) disable iff (!rst_n) !scl_sense |-> !rise_stb); // R7
  AST_HELD_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (busy && !scl_low && !scl_sense) |=> (busy && !scl_low)); // R7
endmodule

bind scl_phase_gen scl_phase_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_sense(scl_sense), .scl_low(scl_low),
  .busy(busy), .fall_stb(fall_stb), .rise_stb(rise_stb)
);

// File: tb/scl_phase_gen_tb.sv
module scl_phase_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [23:0] ctrl_word = '0;
  logic        slave_hold = 1'b0;
  logic        scl_sense;
  logic        scl_low, busy, fall_stb, rise_stb;

  int vecs = 0;
  int fails = 0;
  int stretch_amt = 0;
  int exp_lo_q[$];
  int exp_hi_q[$];
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign scl_sense = !scl_low && !slave_hold;

  scl_phase_gen u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ctrl_word(ctrl_word),
    .scl_sense(scl_sense), .scl_low(scl_low), .busy(busy),
    .fall_stb(fall_stb), .rise_stb(rise_stb)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lo_of(input logic [23:0] c);
    return int'(c[7:0]) + 3;
  endfunction

  function automatic int hi_of(input logic [23:0] c);
    return (c[23:16] == 8'd0) ? int'(c[7:0]) + 3 : int'(c[23:16]) + 3;
  endfunction

  // monitor: slave model plus length measurement
  int  lowc = 0, hic = 0;
  bit  prev_low = 1'b0;
  int  holdc = 0;
  always begin
    @(negedge clk);
    if (prev_low && !scl_low) holdc = stretch_amt;
    else if (holdc > 0) holdc--;
    prev_low = scl_low;
    slave_hold = (holdc > 0);
    #1;
    if (rst_n) begin
      if (scl_low) begin
        if (lowc == 0) check_eq("R8 fall_stb at low start", int'(fall_stb), 1);
        lowc++;
      end else if (lowc > 0) begin
        if (exp_lo_q.size() == 0) check_eq("R2 unexpected low half", lowc, 0);
        else check_eq("R2 low half length", lowc, exp_lo_q.pop_front());
        lowc = 0;
      end
      if (busy && !scl_low && scl_sense) begin
        if (hic == 0) check_eq("R8 rise_stb at high start", int'(rise_stb), 1);
        hic++;
      end else if (hic > 0 && (scl_low || !busy)) begin
        if (exp_hi_q.size() == 0) check_eq("R3 unexpected high half", hic, 0);
        else check_eq("R3 R4 R7 high half length", hic, exp_hi_q.pop_front());
        hic = 0;
      end
    end
  end

  task automatic idle_check(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      if (i == 0 || i == n - 1) begin
        check_eq("R1 R9 idle busy", int'(busy), 0);
        check_eq("R1 R9 idle scl released", int'(scl_low), 0);
        check_eq("R1 idle fall_stb", int'(fall_stb), 0);
      end
    end
  endtask

  task automatic run_seq(input logic [23:0] a, input logic [23:0] b,
                         input int n, input int change_at, input int s);
    int seen;
    stretch_amt = s;
    for (int i = 0; i < n; i++) begin
      exp_lo_q.push_back(i < change_at ? lo_of(a) : lo_of(b));
      exp_hi_q.push_back(i < change_at ? hi_of(a) : hi_of(b));
    end
    @(negedge clk); #1;
    ctrl_word = a;
    enable = 1'b1;
    seen = 0;
    while (seen < n) begin
      @(negedge clk); #1;
      if (fall_stb) begin
        seen++;
        if (seen == change_at) ctrl_word = b;  // R6
        if (seen == n) enable = 1'b0;           // R9
      end
    end
    while (busy) begin
      @(negedge clk); #1;
    end
    repeat (3) @(negedge clk);
    check_eq("R2 R3 all periods consumed", exp_lo_q.size() + exp_hi_q.size(), 0);
    idle_check(8);
    stretch_amt = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_eq("R1 reset busy", int'(busy), 0);
    check_eq("R1 reset scl_low", int'(scl_low), 0);
    check_eq("R1 reset rise_stb", int'(rise_stb), 0);
    rst_n = 1'b1;
    idle_check(5);
    // R4 symmetric with fallback
    run_seq({8'd0, 8'h03, 8'd5}, {8'd0, 8'h03, 8'd5}, 3, 3, 0);
    // R3 asymmetric
    run_seq({8'd5, 8'h03, 8'd10}, {8'd5, 8'h03, 8'd10}, 3, 3, 0);
    // R2 minimum dividers
    run_seq(24'h000000, 24'h000000, 2, 2, 0);
    // R3 R5 largest low, short high, middle byte all ones
    run_seq({8'd1, 8'hFF, 8'd255}, {8'd1, 8'hFF, 8'd255}, 2, 2, 0);
    // R5 middle byte differs only
    run_seq({8'd0, 8'hFF, 8'd4}, {8'd0, 8'hFF, 8'd4}, 2, 2, 0);
    run_seq({8'd0, 8'h00, 8'd4}, {8'd0, 8'h00, 8'd4}, 2, 2, 0);
    // R6 change during period two
    run_seq({8'd0, 8'h03, 8'd6}, {8'd9, 8'h03, 8'd20}, 4, 2, 0);
    // R7 slave stretch longer than high half
    run_seq({8'd0, 8'h03, 8'd2}, {8'd0, 8'h03, 8'd2}, 3, 3, 15);
    run_seq({8'd4, 8'h03, 8'd8}, {8'd4, 8'h03, 8'd8}, 2, 2, 3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      vecs++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end
endmodule